// File: doc/BRIEF.md
# Down-Counting Timer / Counter / PWM Unit

This block is a down-counting timer that can also serve as an event counter or a pulse-width modulator. A period register sets the number of ticks in a cycle. The counter runs from that value down to zero and then reloads. A compare register, together with a selectable relation, produces a compare line. That line drives a pair of complementary PWM outputs. Each output rises only after a programmable dead time has passed since the other output fell. A kill input turns both PWM outputs off at once.

The counter has three ways to run. It can run freely once started. It can run a single pass and then stop. It can count only while the enable input is high. A capture input copies the live count into a readable register. A small register port sets the configuration and reads back the live count, the captured value and a set of sticky event flags. Those flags can be masked onto one interrupt line.

The block uses one clock. The `tick_i` input is a count enable and sets the counting rate.

Top module: `tcpwm_unit`

## Requirements
- R1: After `rst_n` is released, the COUNT register (address 6) reads 0xFFFF, STATUS (address 4) reads 0, CAPTURE (address 5) reads 0, and `irq_o`, `tc_o`, `cmp_o`, `pwm_p_o` and `pwm_n_o` are all low.
- R2: The counter only ever decrements by one per counting tick. When a counting tick finds it at zero, it reloads the PERIOD register (address 1). A period of P therefore gives the sequence P, P-1, ..., 0, P, ... `tc_o` is high exactly while the count is zero.
- R3: `cmp_o` compares the count against COMPARE (address 2) using the relation in CTRL (address 0) bits [4:2]: 0 = count < compare, 1 = count <= compare, 2 = equal, 3 = count >= compare, 4 = count > compare.
- R4: Single-pass mode is CTRL bits [1:0] = 1. It runs P, ..., 0, reloads P on the next tick, and then holds P until it is started again or reloaded.
- R5: Gated mode is CTRL bits [1:0] = 2. The counter decrements on a tick only while `enable_i` is high. Otherwise it holds its value.
- R6: In free-run mode (CTRL bits [1:0] = 0) and in single-pass mode, a rising edge on `enable_i` loads PERIOD and starts counting. A high `reload_i` loads PERIOD on that clock edge and re-arms single-pass mode.
- R7: A rising edge on `capture_i` copies the count held before that edge into CAPTURE. This still holds when the same edge reloads the counter from zero.
- R8: The two PWM outputs are never high together. With `tick_i` high on every clock, the gap between one output falling and the other rising is DEADBAND (address 3, 8 bits) + 1 clock cycles.
- R9: While `kill_i` is high, both PWM outputs are low in the same cycle. After `kill_i` falls, they stay low until the next period start (a start, a reload or a wrap from zero).
- R10: STATUS bit 0 (wrap from zero), bit 1 (compare became true) and bit 2 (capture) are sticky and are set by their events. Writing STATUS clears exactly the bits written as one. `irq_o` is high when any STATUS bit is set whose mask bit is set in CTRL bits [7:5] (bit 5 = wrap, bit 6 = compare, bit 7 = capture).
- R11: With `tick_i` low, the count does not change in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the whole block |
| tick_i | input | 1 | Count-enable tick; sets the counting rate |
| enable_i | input | 1 | Rising edge starts free-run or single-pass mode; gates counting in gated mode |
| reload_i | input | 1 | Loads the period into the counter and re-arms single-pass mode |
| capture_i | input | 1 | Rising edge copies the live count into the capture register |
| kill_i | input | 1 | Forces both PWM outputs low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational from `rd_addr_i` |
| cmp_o | output | 1 | Raw compare result |
| pwm_p_o | output | 1 | PWM output that follows the compare result, with dead time |
| pwm_n_o | output | 1 | Complementary PWM output, with dead time |
| tc_o | output | 1 | High while the count is zero |
| irq_o | output | 1 | Masked OR of the sticky status bits |

## Verification
The case that needs care is a capture that lands on the same edge as the wrap from zero. On that edge the counter and the capture register both change. The event flags for the wrap and the capture are also set on that edge. The bench waits until the COUNT read shows zero and then raises `capture_i`. It expects CAPTURE to read 0, COUNT to read the period, and both STATUS bits 0 and 2 to be set. A second pairing is kill against period start. The bench releases `kill_i` in the middle of a period and expects both outputs to stay low until the next period start. It then expects `pwm_p_o` to come back within the following period.

// File: rtl/tcpwm_pkg.sv
package tcpwm_pkg;

    localparam int ADDR_W = 3;
    localparam int N_EVT  = 3;

    localparam int EVT_WRAP = 0;
    localparam int EVT_CMP  = 1;
    localparam int EVT_CAP  = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_PERIOD   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_COMPARE  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_DEADBAND = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STATUS   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CAPTURE  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_COUNT    = 3'd6;

    typedef enum logic [1:0] {
        RUN_FREE  = 2'd0,
        RUN_ONCE  = 2'd1,
        RUN_GATED = 2'd2
    } run_mode_e;

    typedef enum logic [2:0] {
        REL_LT = 3'd0,
        REL_LE = 3'd1,
        REL_EQ = 3'd2,
        REL_GE = 3'd3,
        REL_GT = 3'd4
    } cmp_rel_e;

endpackage

// File: rtl/tcpwm_core.sv
module tcpwm_core
    import tcpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic             reload_i,
    input  logic             capture_i,
    input  run_mode_e        mode_i,
    input  cmp_rel_e         rel_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             cmp_o,
    output logic             tc_o,
    output logic             period_start_o,
    output logic [N_EVT-1:0] evt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] cap;
        logic             run;
        logic             done;
        logic             en_prev;
        logic             cap_prev;
        logic             cmp_prev;
    } core_state_t;

    localparam logic [CNT_W-1:0] COUNT_RST = '1;

    core_state_t q, d;
    logic start, active, step, at_zero, wrap, load, cap_rise, cmp_raw;

    always_comb begin
        case (rel_i)
            REL_LT:  cmp_raw = q.count <  compare_i;
            REL_LE:  cmp_raw = q.count <= compare_i;
            REL_EQ:  cmp_raw = q.count == compare_i;
            REL_GE:  cmp_raw = q.count >= compare_i;
            REL_GT:  cmp_raw = q.count >  compare_i;
            default: cmp_raw = 1'b0;
        endcase

        case (mode_i)
            RUN_FREE:  active = q.run;
            RUN_ONCE:  active = q.run & ~q.done;
            RUN_GATED: active = enable_i;
            default:   active = 1'b0;
        endcase

        start    = enable_i & ~q.en_prev & (mode_i != RUN_GATED);
        step     = tick_i & active;
        at_zero  = (q.count == '0);
        wrap     = step & at_zero;
        load     = start | reload_i | wrap;
        cap_rise = capture_i & ~q.cap_prev;

        d          = q;
        d.en_prev  = enable_i;
        d.cap_prev = capture_i;
        d.cmp_prev = cmp_raw;

        if (start) begin
            d.count = period_i;
            d.run   = 1'b1;
            d.done  = 1'b0;
        end else if (reload_i) begin
            d.count = period_i;
            d.done  = 1'b0;
        end else if (wrap) begin
            d.count = period_i;
            if (mode_i == RUN_ONCE) d.done = 1'b1;
        end else if (step) begin
            d.count = q.count - 1'b1;
        end

        if (cap_rise) d.cap = q.count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.count    <= COUNT_RST;
            q.cap      <= '0;
            q.run      <= 1'b0;
            q.done     <= 1'b0;
            q.en_prev  <= 1'b0;
            q.cap_prev <= 1'b0;
            q.cmp_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign count_o        = q.count;
    assign capture_o      = q.cap;
    assign cmp_o          = cmp_raw;
    assign tc_o           = at_zero;
    assign period_start_o = load;

    always_comb begin
        evt_o           = '0;
        evt_o[EVT_WRAP] = wrap;
        evt_o[EVT_CMP]  = cmp_raw & ~q.cmp_prev;
        evt_o[EVT_CAP]  = cap_rise;
    end

    AST_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n) ($past(step) && !$past(load)) |-> (q.count == $past(q.count) - 1'b1)); // R2
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) $past(wrap) && !$past(start) && !$past(reload_i) |-> (q.count == $past(period_i))); // R2
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!$past(tick_i) && !$past(start) && !$past(reload_i)) |-> $stable(q.count)); // R11
    AST_ONCE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (mode_i == RUN_ONCE && q.done && !start && !reload_i) |=> $stable(q.count)); // R4
    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n) $past(cap_rise) |-> (q.cap == $past(q.count))); // R7

endmodule

// File: rtl/tcpwm_deadband.sv
module tcpwm_deadband #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            want_i,
    input  logic [DB_W-1:0] dead_i,
    output logic            p_o,
    output logic            n_o
);

    typedef struct packed {
        logic            p;
        logic            n;
        logic [DB_W-1:0] wait_cnt;
    } db_state_t;

    db_state_t q, d;

    always_comb begin
        d = q;
        if (want_i) begin
            if (q.n) begin
                d.n        = 1'b0;
                d.wait_cnt = dead_i;
            end else if (!q.p) begin
                if (q.wait_cnt == '0) d.p = 1'b1;
                else if (tick_i)      d.wait_cnt = q.wait_cnt - 1'b1;
            end
        end else begin
            if (q.p) begin
                d.p        = 1'b0;
                d.wait_cnt = dead_i;
            end else if (!q.n) begin
                if (q.wait_cnt == '0) d.n = 1'b1;
                else if (tick_i)      d.wait_cnt = q.wait_cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.p        <= 1'b0;
            q.n        <= 1'b0;
            q.wait_cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign p_o = q.p;
    assign n_o = q.n;

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(q.p && q.n)); // R8
    AST_P_RISE_AFTER_N: assert property (@(posedge clk) disable iff (!rst_n) $rose(q.p) |-> !$past(q.n)); // R8
    AST_N_RISE_AFTER_P: assert property (@(posedge clk) disable iff (!rst_n) $rose(q.n) |-> !$past(q.p)); // R8

endmodule

// File: rtl/tcpwm_regs.sv
module tcpwm_regs
    import tcpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DB_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  capture_i,
    output run_mode_e         mode_o,
    output cmp_rel_e          rel_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  compare_o,
    output logic [DB_W-1:0]   dead_o,
    output logic              irq_o
);

    localparam int MODE_LSB = 0;
    localparam int REL_LSB  = MODE_LSB + 2;
    localparam int MASK_LSB = REL_LSB + 3;
    localparam int CTRL_W   = MASK_LSB + N_EVT;

    typedef struct packed {
        run_mode_e        mode;
        cmp_rel_e         rel;
        logic [N_EVT-1:0] mask;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] compare;
        logic [DB_W-1:0]  dead;
        logic [N_EVT-1:0] status;
    } reg_state_t;

    reg_state_t q, d;
    logic [N_EVT-1:0] clr;
    logic [CTRL_W-1:0] ctrl_view;

    always_comb begin
        d   = q;
        clr = '0;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADR_CTRL: begin
                    d.mode = run_mode_e'(wr_data_i[MODE_LSB +: 2]);
                    d.rel  = cmp_rel_e'(wr_data_i[REL_LSB +: 3]);
                    d.mask = wr_data_i[MASK_LSB +: N_EVT];
                end
                ADR_PERIOD:   d.period  = wr_data_i;
                ADR_COMPARE:  d.compare = wr_data_i;
                ADR_DEADBAND: d.dead    = wr_data_i[DB_W-1:0];
                ADR_STATUS:   clr       = wr_data_i[N_EVT-1:0];
                default: ;
            endcase
        end
        d.status = (q.status & ~clr) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mode    <= RUN_FREE;
            q.rel     <= REL_LT;
            q.mask    <= '0;
            q.period  <= '1;
            q.compare <= '0;
            q.dead    <= '0;
            q.status  <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctrl_view = {q.mask, q.rel, q.mode};

    always_comb begin
        case (rd_addr_i)
            ADR_CTRL:     rd_data_o = CNT_W'(ctrl_view);
            ADR_PERIOD:   rd_data_o = q.period;
            ADR_COMPARE:  rd_data_o = q.compare;
            ADR_DEADBAND: rd_data_o = CNT_W'(q.dead);
            ADR_STATUS:   rd_data_o = CNT_W'(q.status);
            ADR_CAPTURE:  rd_data_o = capture_i;
            ADR_COUNT:    rd_data_o = count_i;
            default:      rd_data_o = '0;
        endcase
    end

    assign mode_o    = q.mode;
    assign rel_o     = q.rel;
    assign period_o  = q.period;
    assign compare_o = q.compare;
    assign dead_o    = q.dead;
    assign irq_o     = |(q.status & q.mask);

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en_i && wr_addr_i == ADR_STATUS) |=> ((q.status & $past(q.status)) == $past(q.status))); // R10
    AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && wr_addr_i == ADR_STATUS && evt_i == '0) |=> ((q.status & $past(wr_data_i[N_EVT-1:0])) == '0)); // R10

endmodule

// File: rtl/tcpwm_unit.sv
module tcpwm_unit
    import tcpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DB_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic                         enable_i,
    input  logic                         reload_i,
    input  logic                         capture_i,
    input  logic                         kill_i,
    input  logic                         wr_en_i,
    input  logic [tcpwm_pkg::ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]             wr_data_i,
    input  logic [tcpwm_pkg::ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]             rd_data_o,
    output logic                         cmp_o,
    output logic                         pwm_p_o,
    output logic                         pwm_n_o,
    output logic                         tc_o,
    output logic                         irq_o
);

    typedef struct packed {
        logic kill_hold;
    } top_state_t;

    top_state_t q, d;

    run_mode_e        mode;
    cmp_rel_e         rel;
    logic [CNT_W-1:0] period, compare, count, cap_val;
    logic [DB_W-1:0]  dead;
    logic [N_EVT-1:0] evt;
    logic             cmp_raw, period_start, db_p, db_n, out_gate;

    tcpwm_regs #(.CNT_W(CNT_W), .DB_W(DB_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .evt_i     (evt),
        .count_i   (count),
        .capture_i (cap_val),
        .mode_o    (mode),
        .rel_o     (rel),
        .period_o  (period),
        .compare_o (compare),
        .dead_o    (dead),
        .irq_o     (irq_o)
    );

    tcpwm_core #(.CNT_W(CNT_W)) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .enable_i       (enable_i),
        .reload_i       (reload_i),
        .capture_i      (capture_i),
        .mode_i         (mode),
        .rel_i          (rel),
        .period_i       (period),
        .compare_i      (compare),
        .count_o        (count),
        .capture_o      (cap_val),
        .cmp_o          (cmp_raw),
        .tc_o           (tc_o),
        .period_start_o (period_start),
        .evt_o          (evt)
    );

    tcpwm_deadband #(.DB_W(DB_W)) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .want_i (cmp_raw),
        .dead_i (dead),
        .p_o    (db_p),
        .n_o    (db_n)
    );

    always_comb begin
        d = q;
        if (kill_i)            d.kill_hold = 1'b1;
        else if (period_start) d.kill_hold = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.kill_hold <= 1'b0;
        else        q <= d;
    end

    assign out_gate = ~kill_i & ~q.kill_hold;
    assign cmp_o    = cmp_raw;
    assign pwm_p_o  = db_p & out_gate;
    assign pwm_n_o  = db_n & out_gate;

    AST_KILL_NOW: assert property (@(posedge clk) disable iff (!rst_n) kill_i |-> (!pwm_p_o && !pwm_n_o)); // R9
    AST_KILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($fell(kill_i) && !$past(period_start)) |-> (!pwm_p_o && !pwm_n_o)); // R9
    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(pwm_p_o && pwm_n_o)); // R8

endmodule

// File: tb/tcpwm_unit_bench.sv
module tcpwm_unit_bench;

    localparam int HALF_NS = 10;
    localparam logic [2:0] A_CTRL = 3'd0, A_PER = 3'd1, A_CMP = 3'd2, A_DB = 3'd3,
                           A_STAT = 3'd4, A_CAP = 3'd5, A_CNT = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1, enable = 1'b0, reload = 1'b0, capture = 1'b0, kill = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cmp, pwm_p, pwm_n, tc, irq;

    int checks = 0;
    int errors = 0;

    always #HALF_NS clk = ~clk;

    tcpwm_unit u_tcpwm_unit (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .enable_i(enable), .reload_i(reload),
        .capture_i(capture), .kill_i(kill), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cmp_o(cmp),
        .pwm_p_o(pwm_p), .pwm_n_o(pwm_n), .tc_o(tc), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic bit rel_true(input int r, input int c, input int v);
        case (r)
            0: return c < v;
            1: return c <= v;
            2: return c == v;
            3: return c >= v;
            4: return c > v;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_deadband(input int db);
        int gap, seen;
        bit in_gap, prev_high;
        wr(A_CTRL, 16'(3 << 2));
        wr(A_PER, 16'd15);
        wr(A_CMP, 16'd8);
        wr(A_DB, 16'(db));
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        repeat (20) @(negedge clk);
        gap = 0; seen = 0; in_gap = 1'b0; prev_high = 1'b0;
        for (int i = 0; i < 64; i++) begin
            #1;
            chk(!(pwm_p && pwm_n), "R8 outputs overlap", {pwm_p, pwm_n}, 0);
            if (prev_high && !pwm_p && !pwm_n) begin
                in_gap = 1'b1; gap = 1;
            end else if (in_gap && !pwm_p && !pwm_n) begin
                gap++;
            end else if (in_gap) begin
                chk(gap == db + 1, "R8 dead gap length", gap, db + 1);
                in_gap = 1'b0; seen++;
            end
            prev_high = pwm_p | pwm_n;
            @(negedge clk);
        end
        chk(seen >= 4, "R8 dead gaps observed", seen, 4);
    endtask

    initial begin
        #(2 * HALF_NS * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, c0, st;
        int p, expc, found;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CNT, v);  chk(v == 16'hFFFF, "R1 count after reset", v, 16'hFFFF);
        rd(A_STAT, v); chk(v == 0, "R1 status after reset", v, 0);
        rd(A_CAP, v);  chk(v == 0, "R1 capture after reset", v, 0);
        chk(irq == 0, "R1 irq after reset", irq, 0);
        chk(tc == 0 && cmp == 0, "R1 tc/cmp after reset", {tc, cmp}, 0);
        chk(pwm_p == 0 && pwm_n == 0, "R1 pwm after reset", {pwm_p, pwm_n}, 0);

        // R2 R3 R6 sweep: all relations, compare values around a small period
        for (int r = 0; r < 5; r++) begin
            for (int pi = 0; pi < 2; pi++) begin
                p = (pi == 0) ? 3 : 5;
                for (int cv = 0; cv <= p + 1; cv++) begin
                    wr(A_CTRL, 16'(r << 2));
                    wr(A_PER, 16'(p));
                    wr(A_CMP, 16'(cv));
                    enable = 1'b1;
                    @(negedge clk);
                    for (int i = 0; i < 2 * (p + 1); i++) begin
                        expc = p - (i % (p + 1));
                        rd(A_CNT, v);
                        chk(v == 16'(expc), (i == 0) ? "R6 start loads period" : "R2 count sequence", v, expc);
                        chk(cmp == rel_true(r, expc, cv), "R3 compare relation", cmp, rel_true(r, expc, cv));
                        chk(tc == (expc == 0), "R2 tc at zero", tc, expc == 0);
                        @(negedge clk);
                    end
                    enable = 1'b0;
                end
            end
        end

        // R4 single pass with R10 wrap flag and irq
        wr(A_CTRL, 16'(1 | (1 << 5)));
        wr(A_PER, 16'd3);
        repeat (14) @(negedge clk);
        wr(A_STAT, 16'h7);
        rd(A_STAT, v); chk(v[0] == 1'b0, "R10 status cleared", v[0], 0);
        chk(irq == 0, "R10 irq low after clear", irq, 0);
        enable = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            expc = (i < 4) ? 3 - i : 3;
            rd(A_CNT, v);
            chk(v == 16'(expc), "R4 single pass count", v, expc);
            if (i == 3) begin
                rd(A_STAT, st); chk(st[0] == 1'b0, "R10 wrap flag before wrap", st[0], 0);
                chk(irq == 0, "R10 irq before wrap", irq, 0);
            end
            if (i == 4) begin
                rd(A_STAT, st); chk(st[0] == 1'b1, "R10 wrap flag set", st[0], 1);
                chk(irq == 1, "R10 irq on masked wrap", irq, 1);
            end
            @(negedge clk);
        end

        // R6 reload input re-arms single pass
        wr(A_PER, 16'd6);
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rd(A_CNT, v); chk(v == 16'(6 - i), "R6 reload and count", v, 6 - i);
            @(negedge clk);
        end
        enable = 1'b0;

        // R5 gated mode
        wr(A_CTRL, 16'd2);
        wr(A_PER, 16'd9);
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rd(A_CNT, v); chk(v == 16'd9, "R5 hold while disabled", v, 9);
            @(negedge clk);
        end
        enable = 1'b1;
        @(negedge clk);
        rd(A_CNT, v); chk(v == 16'd8, "R5 count while enabled", v, 8);
        @(negedge clk);
        rd(A_CNT, v); chk(v == 16'd7, "R5 count while enabled", v, 7);
        enable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd(A_CNT, v); chk(v == 16'd7, "R5 hold after disable", v, 7);
        end

        // R11 tick low freezes counting
        enable = 1'b1;
        @(negedge clk);
        rd(A_CNT, c0);
        tick = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd(A_CNT, v); chk(v == c0, "R11 hold without tick", v, c0);
        end
        tick = 1'b1;
        @(negedge clk);
        rd(A_CNT, v); chk(v == c0 - 16'd1, "R11 resume on tick", v, c0 - 16'd1);
        enable = 1'b0;

        // R7 capture, R10 mask and clear
        wr(A_CTRL, 16'(1 << 7));
        wr(A_PER, 16'd20);
        enable = 1'b1;
        repeat (5) @(negedge clk);
        wr(A_STAT, 16'h7);
        for (int k = 0; k < 2; k++) begin
            rd(A_CNT, c0);
            capture = 1'b1;
            @(negedge clk);
            capture = 1'b0;
            rd(A_CAP, v); chk(v == c0, "R7 captured count", v, c0);
            rd(A_STAT, st); chk(st[2] == 1'b1, "R10 capture flag", st[2], 1);
            chk(irq == 1, "R10 irq on masked capture", irq, 1);
            repeat (7) @(negedge clk);
        end
        wr(A_STAT, 16'h1);
        rd(A_STAT, st); chk(st[2] == 1'b1, "R10 unwritten bit stays", st[2], 1);
        repeat (25) @(negedge clk);
        rd(A_STAT, st); chk(st[0] == 1'b1, "R10 wrap flag sticky", st[0], 1);
        wr(A_STAT, 16'h4);
        rd(A_STAT, st); chk(st[2] == 1'b0, "R10 capture flag cleared", st[2], 0);
        chk(irq == 0, "R10 irq ignores unmasked bits", irq, 0);

        // R7 capture on the wrap edge
        found = 0;
        for (int i = 0; i < 30 && found == 0; i++) begin
            rd(A_CNT, v);
            if (v == 0) found = 1;
            else @(negedge clk);
        end
        chk(found == 1, "R7 zero reached", found, 1);
        wr_en = 1'b0;
        capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        rd(A_CAP, v); chk(v == 0, "R7 capture at wrap", v, 0);
        rd(A_CNT, v); chk(v == 16'd20, "R7 reload alongside capture", v, 20);
        rd(A_STAT, st); chk(st[2] && st[0], "R7 both flags at wrap", st[2:0], 5);
        enable = 1'b0;

        // R8 dead time
        run_deadband(2);
        run_deadband(0);
        run_deadband(4);
        run_deadband(2);

        // R9 kill
        found = 0;
        for (int i = 0; i < 40 && found == 0; i++) begin
            #1;
            if (pwm_p) found = 1;
            else @(negedge clk);
        end
        chk(found == 1, "R9 pwm high before kill", found, 1);
        kill = 1'b1;
        #1;
        chk(!pwm_p && !pwm_n, "R9 kill same cycle", {pwm_p, pwm_n}, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(!pwm_p && !pwm_n, "R9 low while kill", {pwm_p, pwm_n}, 0);
        end
        @(negedge clk);
        kill = 1'b0;
        for (int i = 0; i < 20; i++) begin
            rd(A_CNT, v);
            if (v == 16'd15) break;
            chk(!pwm_p && !pwm_n, "R9 held until period start", {pwm_p, pwm_n}, 0);
            @(negedge clk);
        end
        found = 0;
        for (int i = 0; i < 16; i++) begin
            #1;
            if (pwm_p) found = 1;
            @(negedge clk);
        end
        chk(found == 1, "R9 outputs resume", found, 1);
        enable = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule